// File: doc/BRIEF.md
# Multi-mode operand address generator

This block fetches the second source operand of a two-operand ALU instruction. A start pulse presents a 4-bit mode code, two register selects (base and index), a 32-bit instruction constant and an operand size. The block reads its internal 32-entry register file, computes an effective address when the mode needs one, reads the data memory through a combinational word-addressed read port, applies any base-register side effect, and then pulses `done` with the operand value on `operand`. The value stays on `operand` until the next completion.

The register file is loaded through a write port at the block's edge. Memory answers in the same cycle the block drives `mem_addr` with `mem_rd` high. Each memory read therefore costs one cycle. Modes with no memory access finish one cycle after start. Modes with a single read finish after two cycles. The double-read mode finishes after three. While a request is in flight, `mem_rd` stays high and further start pulses are ignored.

Mode codes: 0 register, 1 immediate, 2 displacement, 3 register-indirect, 4 indexed, 5 direct, 6 memory-indirect, 7 auto-increment, 8 auto-decrement, 9 scaled. Codes 10 to 15 are illegal.

Top module: `opag_top`

## Requirements
- R1: Mode 0 returns the content of the base register, with `done` high one cycle after start and no memory read.
- R2: Mode 1 returns `konst` unchanged, with `done` one cycle after start and no memory read.
- R3: The single-read modes each issue exactly one memory read, and `done` follows two cycles after start. The read address is `konst`+R[base] for mode 2, R[base] for mode 3, R[base]+R[index] for mode 4 and `konst` for mode 5. The operand is the word returned by that read.
- R4: Mode 6 first reads at R[base]. It then reads at the word that first read returned. The operand is the second word, and `done` follows three cycles after start.
- R5: Mode 7 reads at the old R[base]. By the time `done` is high, R[base] holds old+`opsize`.
- R6: Mode 8 writes R[base]-`opsize` into the base register. It then reads memory at that new value.
- R7: Mode 9 reads at `konst`+R[base]+R[index]*`opsize`, wrapping at 32 bits, and finishes two cycles after start.
- R8: Register 0 reads as zero. Writes to it from the write port are ignored, and so are base updates from modes 7 and 8.
- R9: Mode codes 10 to 15 raise `illegal` together with `done` one cycle after start. The operand becomes 0, no memory read is made and no register changes.
- R10: A start pulse that arrives while a request is in flight is ignored. `done` is never high while `mem_rd` is high.
- R11: After reset, `done`, `illegal` and `mem_rd` are low and `operand` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin resolving one operand |
| mode | input | 4 | Addressing mode code |
| base_sel | input | 5 | Base register select |
| index_sel | input | 5 | Index register select |
| konst | input | 32 | Immediate, displacement or absolute address |
| opsize | input | 4 | Operand size d used for stepping and scaling |
| rf_we | input | 1 | Register file write enable |
| rf_waddr | input | 5 | Register file write select |
| rf_wdata | input | 32 | Register file write data |
| mem_rd | output | 1 | Memory read strobe, high while busy |
| mem_addr | output | 32 | Memory word address |
| mem_rdata | input | 32 | Memory read data, same cycle |
| done | output | 1 | Operand ready pulse |
| illegal | output | 1 | Unused mode code, valid with done |
| operand | output | 32 | Resolved operand value |

## Verification
A wrong state code appears at once as a wrong number of `mem_rd` cycles, or as `done` arriving one cycle early or late, so every operation checks its latency and its read-address sequence. A wrong address register shows up at `mem_addr` during the read cycle itself, and through the hashed memory model it then gives a wrong operand at `done`. A base update that is missing or wrong stays hidden until a later mode-0 read of that register, or a later memory access through it. The bench therefore keeps a shadow register file and issues random operations that reuse the same registers.

// File: rtl/opag_pkg.sv
package opag_pkg;
  localparam logic [3:0] MD_REG  = 4'd0;
  localparam logic [3:0] MD_IMM  = 4'd1;
  localparam logic [3:0] MD_DISP = 4'd2;
  localparam logic [3:0] MD_RIND = 4'd3;
  localparam logic [3:0] MD_IDX  = 4'd4;
  localparam logic [3:0] MD_ABS  = 4'd5;
  localparam logic [3:0] MD_MIND = 4'd6;
  localparam logic [3:0] MD_AINC = 4'd7;
  localparam logic [3:0] MD_ADEC = 4'd8;
  localparam logic [3:0] MD_SCL  = 4'd9;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PTR  = 2'd1,
    ST_DATA = 2'd2
  } opag_state_e;
endpackage

// File: rtl/opag_regfile.sv
module opag_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] ra_b,
  input  logic [IW-1:0] ra_x,
  output logic [DW-1:0] rd_b,
  output logic [DW-1:0] rd_x,
  input  logic          we_ext,
  input  logic [IW-1:0] wa_ext,
  input  logic [DW-1:0] wd_ext,
  input  logic          we_upd,
  input  logic [IW-1:0] wa_upd,
  input  logic [DW-1:0] wd_upd
);
  logic [DW-1:0] regs [NREG];

  // Entry 0 is a hard zero; the others take a base update ahead of a port write.
  for (genvar g = 0; g < NREG; g++) begin : g_ent
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_reg
      logic          upd_hit, ext_hit, ent_en;
      logic [DW-1:0] ent_d;
      assign upd_hit = we_upd && (wa_upd == IW'(g));
      assign ext_hit = we_ext && (wa_ext == IW'(g));
      assign ent_en  = upd_hit || ext_hit;
      assign ent_d   = upd_hit ? wd_upd : wd_ext;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      regs[g] <= '0;
        else if (ent_en) regs[g] <= ent_d;
      end
    end
  end

  assign rd_b = regs[ra_b];
  assign rd_x = regs[ra_x];
endmodule

// File: rtl/opag_addr_calc.sv
module opag_addr_calc import opag_pkg::*; #(
  parameter int DW = 32,
  parameter int SW = 4
) (
  input  logic [3:0]    mode,
  input  logic [DW-1:0] rb,
  input  logic [DW-1:0] rx,
  input  logic [DW-1:0] konst,
  input  logic [SW-1:0] opsize,
  output logic [DW-1:0] addr,
  output logic [DW-1:0] val,
  output logic          uses_mem,
  output logic          indirect,
  output logic          bad,
  output logic          upd,
  output logic [DW-1:0] upd_val
);
  logic [DW-1:0] step;
  logic [DW-1:0] scaled;

  assign step   = {{(DW-SW){1'b0}}, opsize};
  assign scaled = rx * step;

  always_comb begin
    addr     = '0;
    val      = '0;
    uses_mem = 1'b1;
    indirect = 1'b0;
    bad      = 1'b0;
    upd      = 1'b0;
    upd_val  = rb;
    case (mode)
      MD_REG:  begin uses_mem = 1'b0; val = rb;    end
      MD_IMM:  begin uses_mem = 1'b0; val = konst; end
      MD_DISP: addr = konst + rb;
      MD_RIND: addr = rb;
      MD_IDX:  addr = rb + rx;
      MD_ABS:  addr = konst;
      MD_MIND: begin addr = rb; indirect = 1'b1; end
      MD_AINC: begin addr = rb; upd = 1'b1; upd_val = rb + step; end
      MD_ADEC: begin addr = rb - step; upd = 1'b1; upd_val = rb - step; end
      MD_SCL:  addr = konst + rb + scaled;
      default: begin uses_mem = 1'b0; bad = 1'b1; end
    endcase
  end
endmodule

// File: rtl/opag_top.sv
module opag_top import opag_pkg::*; #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  parameter int SW   = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [IW-1:0] base_sel,
  input  logic [IW-1:0] index_sel,
  input  logic [DW-1:0] konst,
  input  logic [SW-1:0] opsize,
  input  logic          rf_we,
  input  logic [IW-1:0] rf_waddr,
  input  logic [DW-1:0] rf_wdata,
  output logic          mem_rd,
  output logic [DW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic          illegal,
  output logic [DW-1:0] operand
);
  opag_state_e   st_q, st_d;
  logic [DW-1:0] addr_q, addr_d, opnd_q, opnd_d;
  logic          addr_en, opnd_en;
  logic          done_q, done_d, ill_q, ill_d;
  logic          upd_we;

  logic [DW-1:0] rb, rx, c_addr, c_val, c_upd_val;
  logic          c_mem, c_ind, c_bad, c_upd;

  opag_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .ra_b   (base_sel),
    .ra_x   (index_sel),
    .rd_b   (rb),
    .rd_x   (rx),
    .we_ext (rf_we),
    .wa_ext (rf_waddr),
    .wd_ext (rf_wdata),
    .we_upd (upd_we),
    .wa_upd (base_sel),
    .wd_upd (c_upd_val)
  );

  opag_addr_calc #(.DW(DW), .SW(SW)) u_calc (
    .mode     (mode),
    .rb       (rb),
    .rx       (rx),
    .konst    (konst),
    .opsize   (opsize),
    .addr     (c_addr),
    .val      (c_val),
    .uses_mem (c_mem),
    .indirect (c_ind),
    .bad      (c_bad),
    .upd      (c_upd),
    .upd_val  (c_upd_val)
  );

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    addr_en = 1'b0;
    opnd_d  = opnd_q;
    opnd_en = 1'b0;
    done_d  = 1'b0;
    ill_d   = 1'b0;
    upd_we  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (c_bad) begin
            done_d  = 1'b1;
            ill_d   = 1'b1;
            opnd_d  = '0;
            opnd_en = 1'b1;
          end else if (!c_mem) begin
            done_d  = 1'b1;
            opnd_d  = c_val;
            opnd_en = 1'b1;
          end else begin
            addr_d  = c_addr;
            addr_en = 1'b1;
            st_d    = c_ind ? ST_PTR : ST_DATA;
            upd_we  = c_upd && (base_sel != '0);
          end
        end
      end
      ST_PTR: begin
        addr_d  = mem_rdata;
        addr_en = 1'b1;
        st_d    = ST_DATA;
      end
      ST_DATA: begin
        opnd_d  = mem_rdata;
        opnd_en = 1'b1;
        done_d  = 1'b1;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      ill_q  <= ill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       opnd_q <= '0;
    else if (opnd_en) opnd_q <= opnd_d;
  end

  assign mem_rd   = (st_q != ST_IDLE);
  assign mem_addr = addr_q;
  assign done     = done_q;
  assign illegal  = ill_q;
  assign operand  = opnd_q;
endmodule

// File: rtl/opag_chk.sv
module opag_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [3:0]    mode,
  input logic [DW-1:0] konst,
  input logic          mem_rd,
  input logic          done,
  input logic          illegal,
  input logic [DW-1:0] operand
);
  logic go, quick, one_rd, two_rd, bad;
  assign go     = start && !mem_rd;
  assign quick  = (mode == 4'd0) || (mode == 4'd1);
  assign two_rd = (mode == 4'd6);
  assign bad    = (mode > 4'd9);
  assign one_rd = !quick && !two_rd && !bad;

  AST_QUICK_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    go && quick |=> done && !illegal && !mem_rd); // R1
  AST_IMM_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    go && (mode == 4'd1) |=> operand == $past(konst)); // R2
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    go && one_rd |=> mem_rd && !done ##1 done && !mem_rd); // R3
  AST_TWO_READS: assert property (@(posedge clk) disable iff (!rst_n)
    go && two_rd |=> mem_rd ##1 mem_rd ##1 done && !mem_rd); // R4
  AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    go && bad |=> done && illegal && !mem_rd && (operand == '0)); // R9
  AST_ILL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done); // R9
  AST_QUIET_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !done); // R10
  AST_DONE_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start) || $past(mem_rd)); // R10
endmodule

bind opag_top opag_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .mode    (mode),
  .konst   (konst),
  .mem_rd  (mem_rd),
  .done    (done),
  .illegal (illegal),
  .operand (operand)
);

// File: tb/opag_top_tb.sv
module opag_top_tb;
  logic        clk, rst_n, start, rf_we, mem_rd, done, illegal;
  logic [3:0]  mode, opsize;
  logic [4:0]  base_sel, index_sel, rf_waddr;
  logic [31:0] konst, rf_wdata, mem_addr, mem_rdata, operand;

  int checks = 0;
  int fails  = 0;
  logic [31:0] shadow [32];
  int          rd_cnt;
  logic [31:0] rd_log [4];

  opag_top u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .base_sel(base_sel), .index_sel(index_sel), .konst(konst), .opsize(opsize),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .done(done), .illegal(illegal), .operand(operand)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return ((a ^ 32'hA5A5_0F0F) * 32'h0001_0003) + 32'h0000_1234;
  endfunction
  assign mem_rdata = memf(mem_addr);

  always @(negedge clk) begin
    if (mem_rd && rd_cnt < 4) begin
      rd_log[rd_cnt] = mem_addr;
      rd_cnt = rd_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] m);
    case (m)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4, 4'd5: return "R3";
      4'd6: return "R4";
      4'd7: return "R5";
      4'd8: return "R6";
      4'd9: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    rf_we = 1'b1; rf_waddr = a; rf_wdata = d;
    @(negedge clk);
    rf_we = 1'b0;
    if (a != 5'd0) shadow[a] = d;
  endtask

  task automatic run_op(input logic [3:0] m, input logic [4:0] b, input logic [4:0] x,
                        input logic [31:0] k, input logic [3:0] d, input bit poke);
    logic [31:0] rb, rx, dx, a1, e_val;
    int          e_lat, e_nrd, n;
    string       rq;
    rq = req_of(m);
    rb = shadow[b]; rx = shadow[x]; dx = {28'd0, d};
    a1 = 32'd0; e_val = 32'd0; e_lat = 2; e_nrd = 1;
    case (m)
      4'd0: begin e_val = rb; e_lat = 1; e_nrd = 0; end
      4'd1: begin e_val = k;  e_lat = 1; e_nrd = 0; end
      4'd2: a1 = k + rb;
      4'd3: a1 = rb;
      4'd4: a1 = rb + rx;
      4'd5: a1 = k;
      4'd6: begin a1 = rb; e_lat = 3; e_nrd = 2; end
      4'd7: a1 = rb;
      4'd8: a1 = rb - dx;
      4'd9: a1 = k + rb + rx * dx;
      default: begin e_lat = 1; e_nrd = 0; end
    endcase
    if (m == 4'd6) e_val = memf(memf(a1));
    else if (e_nrd == 1) e_val = memf(a1);
    @(negedge clk);
    rd_cnt = 0;
    start = 1'b1; mode = m; base_sel = b; index_sel = x; konst = k; opsize = d;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (poke && n == 1) begin mode = 4'd0; konst = ~k; end
      else start = 1'b0;
    end while (!done && n < 10);
    start = 1'b0;
    if (poke) chk("R10", 32'(n), 32'(e_lat));
    else chk(rq, 32'(n), 32'(e_lat));
    chk(rq, operand, e_val);
    chk(rq, {31'd0, illegal}, {31'd0, m > 4'd9});
    chk(rq, 32'(rd_cnt), 32'(e_nrd));
    if (e_nrd >= 1) chk(rq, rd_log[0], a1);
    if (e_nrd == 2) chk(rq, rd_log[1], memf(a1));
    if (b != 5'd0 && m == 4'd7) shadow[b] = rb + dx;
    if (b != 5'd0 && m == 4'd8) shadow[b] = rb - dx;
  endtask

  task automatic read_reg(input logic [4:0] r, input string rq);
    run_op(4'd0, r, 5'd0, 32'd0, 4'd0, 1'b0);
    chk(rq, operand, shadow[r]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20240611);
    start = 0; mode = 0; base_sel = 0; index_sel = 0; konst = 0; opsize = 0;
    rf_we = 0; rf_waddr = 0; rf_wdata = 0; rd_cnt = 0;
    for (int i = 0; i < 32; i++) shadow[i] = 32'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", {29'd0, done, illegal, mem_rd}, 32'd0);
    chk("R11", operand, 32'd0);
    rst_n = 1'b1;

    for (int i = 1; i < 32; i++) wr_reg(5'(i), $urandom);
    wr_reg(5'd3, 32'h0000_1000);
    wr_reg(5'd4, 32'h0000_0007);

    // directed cases, one per mode
    run_op(4'd0, 5'd3, 5'd0, 32'd0, 4'd0, 1'b0);            // R1
    run_op(4'd1, 5'd3, 5'd0, 32'hDEAD_BEEF, 4'd0, 1'b0);    // R2
    run_op(4'd2, 5'd3, 5'd0, 32'd100, 4'd0, 1'b0);          // R3
    run_op(4'd3, 5'd3, 5'd0, 32'd0, 4'd0, 1'b0);            // R3
    run_op(4'd4, 5'd3, 5'd4, 32'd0, 4'd0, 1'b0);            // R3
    run_op(4'd5, 5'd0, 5'd0, 32'd1001, 4'd0, 1'b0);         // R3
    run_op(4'd6, 5'd3, 5'd0, 32'd0, 4'd0, 1'b0);            // R4
    run_op(4'd7, 5'd3, 5'd0, 32'd0, 4'd4, 1'b0);            // R5
    read_reg(5'd3, "R5");
    run_op(4'd8, 5'd3, 5'd0, 32'd0, 4'd8, 1'b0);            // R6
    read_reg(5'd3, "R6");
    run_op(4'd8, 5'd5, 5'd0, 32'd0, 4'd4, 1'b0);            // R6
    run_op(4'd3, 5'd5, 5'd0, 32'd0, 4'd0, 1'b0);            // R6 follow-up access
    run_op(4'd9, 5'd3, 5'd4, 32'd100, 4'd4, 1'b0);          // R7
    wr_reg(5'd6, 32'hFFFF_FFF0);
    run_op(4'd9, 5'd6, 5'd6, 32'hFFFF_FF00, 4'd15, 1'b0);   // R7 wrap

    // R8 register 0
    wr_reg(5'd0, 32'h1234_5678);
    read_reg(5'd0, "R8");
    run_op(4'd7, 5'd0, 5'd0, 32'd0, 4'd4, 1'b0);
    read_reg(5'd0, "R8");
    run_op(4'd8, 5'd0, 5'd0, 32'd0, 4'd4, 1'b0);
    read_reg(5'd0, "R8");

    // R9 illegal codes leave registers alone
    run_op(4'd10, 5'd3, 5'd4, 32'd5, 4'd4, 1'b0);
    run_op(4'd15, 5'd3, 5'd4, 32'd5, 4'd4, 1'b0);
    read_reg(5'd3, "R9");

    // R10 start while busy
    run_op(4'd2, 5'd3, 5'd0, 32'd8, 4'd0, 1'b1);
    run_op(4'd6, 5'd4, 5'd0, 32'd0, 4'd0, 1'b1);
    run_op(4'd7, 5'd7, 5'd0, 32'd0, 4'd2, 1'b1);
    read_reg(5'd7, "R10");

    // random mix
    for (int i = 0; i < 120; i++) begin
      if ($urandom_range(0, 4) == 0) wr_reg(5'($urandom_range(0, 31)), $urandom);
      run_op(4'($urandom_range(0, 15)), 5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)),
             $urandom_range(0, 65535), 4'($urandom_range(0, 15)), $urandom_range(0, 5) == 0);
    end
    for (int i = 0; i < 8; i++) read_reg(5'(i), "R5");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule